// File: doc/BRIEF.md
# Run-Ahead Branch Predictor Front End

This block produces instruction fetch addresses ahead of the fetch unit. Each step covers one 32-byte aligned window. Every cycle that queue space allows, the block looks up the current window in a small fully associative fast table and chooses the next window from that result. It then checks the same window against a larger direct-mapped table two cycles later. When the larger table's answer differs from the fast guess, the younger lookups are thrown away and prediction restarts from the larger table's answer. Only windows whose prediction the larger table has confirmed enter an 8-entry fetch target queue. The fetch unit drains that queue at its own pace.

Branch resolution trains both tables through an update port. It also steers the block through a redirect port, which empties the queue and all lookups in flight and restarts prediction at the given window. Each queued entry gives the window address, a taken flag and the address of the next window.

Top module: `bp_front`

## Requirements
- R1: While reset is held and in the cycle it is released the queue is empty (`fq_valid_o`=0); the first window delivered after reset is `BOOT_ADDR` (default 0x1000).
- R2: A window that hits in neither table is delivered with `fq_taken_o`=0 and `fq_target_o` = window address + 32, and the following window is that address.
- R3: Every delivered address has its five low bits zero; a redirect to an unaligned address restarts at that address with the five low bits cleared.
- R4: After an update with `upd_taken_i`=1 for window X and target T, a window X is delivered with `fq_taken_o`=1 and `fq_target_o`=T, and the next window delivered is T.
- R5: After an update with `upd_taken_i`=0 for window X, X is delivered not taken with `fq_target_o` = X + 32.
- R6: The larger table is authoritative. Its index is address bits [12:5] in the 256-entry default, and a differing tag is a miss. If the fast table predicts taken for X but the larger table misses for X, X is delivered not taken.
- R7: When the fast table already agrees with the larger table, the predicted next window is delivered in the cycle after the previous one is popped. When the fast table misses and the larger table hits, the younger lookups are squashed and the next window appears only after a gap of at least one cycle.
- R8: The fast table holds 64 entries and fills new windows in round-robin order. An update to a window already present overwrites that entry in place. An entry survives 63 later updates of new windows and is evicted by the 64th.
- R9: The queue holds 8 entries. While it is full, prediction stalls and no window is dropped or altered. The head stays stable until it is popped, and the windows popped afterwards follow on without a gap.
- R10: A redirect empties the queue by the next cycle and discards lookups in flight; the first window delivered afterwards is the redirect window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| redir_valid_i | input | 1 | Restart prediction and flush |
| redir_addr_i | input | 32 | Restart address (low 5 bits ignored) |
| upd_valid_i | input | 1 | Train both tables this cycle |
| upd_addr_i | input | 32 | Window holding the resolved branch |
| upd_target_i | input | 32 | Resolved target address |
| upd_taken_i | input | 1 | Resolved direction |
| fq_pop_i | input | 1 | Fetch unit consumes the queue head |
| fq_valid_o | output | 1 | Queue head present |
| fq_addr_o | output | 32 | Head window address |
| fq_taken_o | output | 1 | Head window ends in a taken branch |
| fq_target_o | output | 32 | Address of the window after the head |

## Verification
The predictor is driven with an untrained straight-line stream, a taken entry, a not-taken entry and an unaligned restart, and each of these shows a different next-window rule. Two windows that share an index in the larger table make the fast table and the larger table disagree in the direction of taken-versus-not-taken. Sixty-three and then sixty-four fresh updates tell a fast-table hit from an eviction, measured as the gap between popped windows. Holding off pops until the queue fills, and redirecting while it is full, separate stalling from dropping and from flushing.

// File: rtl/bp_pkg.sv
package bp_pkg;
  localparam int ADDR_W  = 32;
  localparam int WIN_LSB = 5;
  localparam int WIN_W   = ADDR_W - WIN_LSB;

  typedef logic [WIN_W-1:0] win_t;

  typedef struct packed {
    logic taken;
    win_t tgt;
  } pred_t;

  typedef struct packed {
    win_t win;
    logic taken;
    win_t nxt;
  } ftq_ent_t;

  function automatic win_t to_win(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:WIN_LSB];
  endfunction

  function automatic logic [ADDR_W-1:0] to_addr(input win_t w);
    return {w, {WIN_LSB{1'b0}}};
  endfunction
endpackage

// File: rtl/bp_ubtb.sv
module bp_ubtb import bp_pkg::*; #(
  parameter int N = 64
) (
  input  logic  clk,
  input  logic  rst_n,
  input  win_t  look_win,
  output logic  hit,
  output pred_t pred,
  input  logic  upd_en,
  input  win_t  upd_win,
  input  pred_t upd_pred
);
  localparam int PW = $clog2(N);

  logic [N-1:0]  vld_q, vld_d;
  win_t          tag_q  [N];
  pred_t         pred_q [N];
  logic [PW-1:0] rr_q, rr_d;
  logic [N-1:0]  lk_m, up_m;
  logic [PW-1:0] wsel;

  for (genvar i = 0; i < N; i++) begin : g_cmp
    assign lk_m[i] = vld_q[i] && (tag_q[i] == look_win);
    assign up_m[i] = vld_q[i] && (tag_q[i] == upd_win);
  end

  always_comb begin
    hit  = |lk_m;
    pred = '0;
    for (int i = 0; i < N; i++) if (lk_m[i]) pred = pred_q[i];
  end

  // existing entry rewritten in place; a new window takes the round-robin slot
  always_comb begin
    wsel = rr_q;
    for (int i = 0; i < N; i++) if (up_m[i]) wsel = PW'(i);
  end

  always_comb begin
    vld_d = vld_q;
    rr_d  = rr_q;
    if (upd_en) begin
      vld_d[wsel] = 1'b1;
      if (!(|up_m)) rr_d = (rr_q == PW'(N-1)) ? '0 : rr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      rr_q  <= '0;
    end else begin
      vld_q <= vld_d;
      rr_q  <= rr_d;
    end
  end

  always_ff @(posedge clk) begin
    if (upd_en) begin
      tag_q[wsel]  <= upd_win;
      pred_q[wsel] <= upd_pred;
    end
  end
endmodule

// File: rtl/bp_mbtb.sv
module bp_mbtb import bp_pkg::*; #(
  parameter int N = 256
) (
  input  logic  clk,
  input  logic  rst_n,
  input  win_t  rd_win,
  output logic  hit,
  output pred_t pred,
  input  logic  upd_en,
  input  win_t  upd_win,
  input  pred_t upd_pred
);
  localparam int IW = $clog2(N);
  localparam int TW = WIN_W - IW;

  logic [N-1:0]    vld_q, vld_d;
  logic [TW-1:0]   tag_q  [N];
  pred_t           pred_q [N];
  logic [IW-1:0]   rd_idx, wr_idx;

  assign rd_idx = rd_win[IW-1:0];
  assign wr_idx = upd_win[IW-1:0];
  assign hit    = vld_q[rd_idx] && (tag_q[rd_idx] == rd_win[WIN_W-1:IW]);
  assign pred   = pred_q[rd_idx];

  always_comb begin
    vld_d = vld_q;
    if (upd_en) vld_d[wr_idx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else        vld_q <= vld_d;
  end

  always_ff @(posedge clk) begin
    if (upd_en) begin
      tag_q[wr_idx]  <= upd_win[WIN_W-1:IW];
      pred_q[wr_idx] <= upd_pred;
    end
  end
endmodule

// File: rtl/bp_ftq.sv
module bp_ftq import bp_pkg::*; #(
  parameter int N = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   flush,
  input  logic                   push,
  input  ftq_ent_t               push_ent,
  input  logic                   pop,
  output logic                   head_vld,
  output ftq_ent_t               head_ent,
  output logic [$clog2(N+1)-1:0] cnt
);
  localparam int PW = $clog2(N);
  localparam int CW = $clog2(N+1);

  ftq_ent_t      mem [N];
  logic [PW-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          push_e, pop_e;

  assign head_vld = (cnt_q != '0);
  assign head_ent = mem[rd_q];
  assign cnt      = cnt_q;
  assign push_e   = push && (cnt_q != CW'(N));
  assign pop_e    = pop && head_vld;

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    cnt_d = cnt_q;
    if (flush) begin
      wr_d  = '0;
      rd_d  = '0;
      cnt_d = '0;
    end else begin
      if (push_e) wr_d = (wr_q == PW'(N-1)) ? '0 : wr_q + 1'b1;
      if (pop_e)  rd_d = (rd_q == PW'(N-1)) ? '0 : rd_q + 1'b1;
      case ({push_e, pop_e})
        2'b10:   cnt_d = cnt_q + 1'b1;
        2'b01:   cnt_d = cnt_q - 1'b1;
        default: cnt_d = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push_e && !flush) mem[wr_q] <= push_ent;
  end
endmodule

// File: rtl/bp_front.sv
module bp_front import bp_pkg::*; #(
  parameter int                UBTB_N    = 64,
  parameter int                MBTB_N    = 256,
  parameter int                FTQ_N     = 8,
  parameter logic [ADDR_W-1:0] BOOT_ADDR = 32'h0000_1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              redir_valid_i,
  input  logic [ADDR_W-1:0] redir_addr_i,
  input  logic              upd_valid_i,
  input  logic [ADDR_W-1:0] upd_addr_i,
  input  logic [ADDR_W-1:0] upd_target_i,
  input  logic              upd_taken_i,
  input  logic              fq_pop_i,
  output logic              fq_valid_o,
  output logic [ADDR_W-1:0] fq_addr_o,
  output logic              fq_taken_o,
  output logic [ADDR_W-1:0] fq_target_o
);
  localparam int CW = $clog2(FTQ_N+1);

  // stage A: current window, fast lookup
  win_t  pc_q, pc_d, guess;
  logic  u_hit;
  pred_t u_pred;
  // stage B: larger table read
  logic  b_v_q, b_v_d;
  win_t  b_pc_q, b_pc_d, b_guess_q, b_guess_d;
  logic  m_hit;
  pred_t m_pred;
  // stage C: compare and commit
  logic  c_v_q, c_v_d, c_mhit_q, c_mhit_d;
  win_t  c_pc_q, c_pc_d, c_guess_q, c_guess_d;
  pred_t c_mpred_q, c_mpred_d;
  logic  auth_taken, push, override, issue;
  win_t  auth_next;
  logic [CW-1:0] ftq_cnt;
  logic [CW:0]   occ;
  ftq_ent_t      head;
  pred_t         upd_pred;
  win_t          upd_win;
  logic          unused_lo_bits;

  assign unused_lo_bits = ^{redir_addr_i[WIN_LSB-1:0], upd_addr_i[WIN_LSB-1:0],
                            upd_target_i[WIN_LSB-1:0]};
  assign upd_win  = to_win(upd_addr_i);
  assign upd_pred = '{taken: upd_taken_i, tgt: to_win(upd_target_i)};

  bp_ubtb #(.N(UBTB_N)) i_ubtb (
    .clk, .rst_n, .look_win(pc_q), .hit(u_hit), .pred(u_pred),
    .upd_en(upd_valid_i), .upd_win(upd_win), .upd_pred(upd_pred)
  );

  bp_mbtb #(.N(MBTB_N)) i_mbtb (
    .clk, .rst_n, .rd_win(b_pc_q), .hit(m_hit), .pred(m_pred),
    .upd_en(upd_valid_i), .upd_win(upd_win), .upd_pred(upd_pred)
  );

  assign guess      = (u_hit && u_pred.taken) ? u_pred.tgt : pc_q + 1'b1;
  assign auth_taken = c_mhit_q && c_mpred_q.taken;
  assign auth_next  = auth_taken ? c_mpred_q.tgt : c_pc_q + 1'b1;
  assign push       = c_v_q && !redir_valid_i;
  assign override   = push && (auth_next != c_guess_q);
  // in-flight lookups hold a reserved queue slot, so a push never meets a full queue
  assign occ        = {1'b0, ftq_cnt} + {{CW{1'b0}}, b_v_q} + {{CW{1'b0}}, c_v_q};
  assign issue      = !redir_valid_i && !override && (occ < (CW+1)'(FTQ_N));

  bp_ftq #(.N(FTQ_N)) i_ftq (
    .clk, .rst_n, .flush(redir_valid_i), .push(push),
    .push_ent('{win: c_pc_q, taken: auth_taken, nxt: auth_next}),
    .pop(fq_pop_i), .head_vld(fq_valid_o), .head_ent(head), .cnt(ftq_cnt)
  );

  assign fq_addr_o   = to_addr(head.win);
  assign fq_taken_o  = head.taken;
  assign fq_target_o = to_addr(head.nxt);

  always_comb begin
    pc_d      = pc_q;
    b_v_d     = issue;
    b_pc_d    = pc_q;
    b_guess_d = guess;
    c_v_d     = b_v_q;
    c_pc_d    = b_pc_q;
    c_guess_d = b_guess_q;
    c_mhit_d  = m_hit;
    c_mpred_d = m_pred;
    if (redir_valid_i) begin
      pc_d  = to_win(redir_addr_i);
      c_v_d = 1'b0;
    end else if (override) begin
      pc_d  = auth_next;
      c_v_d = 1'b0;
    end else if (issue) begin
      pc_d  = guess;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q      <= to_win(BOOT_ADDR);
      b_v_q     <= 1'b0;
      b_pc_q    <= '0;
      b_guess_q <= '0;
      c_v_q     <= 1'b0;
      c_pc_q    <= '0;
      c_guess_q <= '0;
      c_mhit_q  <= 1'b0;
      c_mpred_q <= '0;
    end else begin
      pc_q      <= pc_d;
      b_v_q     <= b_v_d;
      b_pc_q    <= b_pc_d;
      b_guess_q <= b_guess_d;
      c_v_q     <= c_v_d;
      c_pc_q    <= c_pc_d;
      c_guess_q <= c_guess_d;
      c_mhit_q  <= c_mhit_d;
      c_mpred_q <= c_mpred_d;
    end
  end
endmodule

// File: rtl/bp_front_chk.sv
module bp_front_chk import bp_pkg::*; #(
  parameter int FTQ_N = 8
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     redir_valid_i,
  input logic                     fq_pop_i,
  input logic                     fq_valid_o,
  input logic [ADDR_W-1:0]        fq_addr_o,
  input logic                     fq_taken_o,
  input logic [ADDR_W-1:0]        fq_target_o,
  input logic [$clog2(FTQ_N+1)-1:0] ftq_cnt,
  input logic                     push,
  input logic                     override,
  input logic                     b_v_q,
  input logic                     c_v_q
);
  // R9
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ftq_cnt == ($clog2(FTQ_N+1))'(FTQ_N)) |-> !push);

  // R9
  head_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fq_valid_o && !fq_pop_i && !redir_valid_i) |=>
      (fq_valid_o && $stable(fq_addr_o) && $stable(fq_target_o) && $stable(fq_taken_o)));

  // R10
  flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    redir_valid_i |=> !fq_valid_o);

  // R2
  fallthrough_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fq_valid_o && !fq_taken_o) |-> (fq_target_o == fq_addr_o + ADDR_W'(32)));

  // R7
  squash_chk: assert property (@(posedge clk) disable iff (!rst_n)
    override |=> (!b_v_q && !c_v_q));
endmodule

bind bp_front bp_front_chk #(.FTQ_N(FTQ_N)) i_bp_front_chk (
  .clk(clk), .rst_n(rst_n), .redir_valid_i(redir_valid_i), .fq_pop_i(fq_pop_i),
  .fq_valid_o(fq_valid_o), .fq_addr_o(fq_addr_o), .fq_taken_o(fq_taken_o),
  .fq_target_o(fq_target_o), .ftq_cnt(ftq_cnt), .push(push),
  .override(override), .b_v_q(b_v_q), .c_v_q(c_v_q)
);

// File: tb/test_bp_front.sv
`timescale 1ns/1ps
module test_bp_front;
  localparam int CYC = 4;
  localparam logic [31:0] BOOT = 32'h0000_1000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        redir_valid_i = 1'b0;
  logic [31:0] redir_addr_i = '0;
  logic        upd_valid_i = 1'b0;
  logic [31:0] upd_addr_i = '0;
  logic [31:0] upd_target_i = '0;
  logic        upd_taken_i = 1'b0;
  logic        fq_pop_i = 1'b0;
  logic        fq_valid_o;
  logic [31:0] fq_addr_o;
  logic        fq_taken_o;
  logic [31:0] fq_target_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CYC/2) clk = ~clk;

  bp_front #(.BOOT_ADDR(BOOT)) i_bp_front (
    .clk, .rst_n, .redir_valid_i, .redir_addr_i, .upd_valid_i, .upd_addr_i,
    .upd_target_i, .upd_taken_i, .fq_pop_i, .fq_valid_o, .fq_addr_o,
    .fq_taken_o, .fq_target_o
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic pop_expect(input logic [31:0] a, input bit tk, input logic [31:0] tg,
                            input string req);
    int w = 0;
    while (!fq_valid_o && w < 60) begin
      @(negedge clk);
      w++;
    end
    check(fq_valid_o, req, "head valid", {31'd0, fq_valid_o}, 32'd1);
    check(fq_addr_o == a, req, "addr", fq_addr_o, a);
    check(fq_taken_o == tk, req, "taken", {31'd0, fq_taken_o}, {31'd0, tk});
    check(fq_target_o == tg, req, "target", fq_target_o, tg);
    fq_pop_i = 1'b1;
    @(negedge clk);
    fq_pop_i = 1'b0;
  endtask

  task automatic redirect(input logic [31:0] a, input string req);
    redir_valid_i = 1'b1;
    redir_addr_i  = a;
    @(negedge clk);
    redir_valid_i = 1'b0;
    check(!fq_valid_o, req, "empty after redirect", {31'd0, fq_valid_o}, 32'd0);
  endtask

  task automatic update(input logic [31:0] a, input logic [31:0] t, input bit tk);
    upd_valid_i  = 1'b1;
    upd_addr_i   = a;
    upd_target_i = t;
    upd_taken_i  = tk;
    @(negedge clk);
    upd_valid_i  = 1'b0;
  endtask

  // pops taken window x, returns cycles the head stays empty before t appears
  task automatic gap_after(input logic [31:0] x, input logic [31:0] t,
                           input string req, output int gap);
    redirect(x, "R10");
    pop_expect(x, 1'b1, t, req);
    gap = 0;
    while (!fq_valid_o && gap < 40) begin
      @(negedge clk);
      gap++;
    end
    pop_expect(t, 1'b0, t + 32, req);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1: empty while held
    check(!fq_valid_o, "R1", "empty in reset", {31'd0, fq_valid_o}, 32'd0);
    rst_n = 1'b1;
    check(!fq_valid_o, "R1", "empty at release", {31'd0, fq_valid_o}, 32'd0);
    pop_expect(BOOT, 1'b0, BOOT + 32, "R1");
    pop_expect(BOOT + 32, 1'b0, BOOT + 64, "R2");
    pop_expect(BOOT + 64, 1'b0, BOOT + 96, "R2");
  endtask

  task automatic t_taken();
    update(32'h2000, 32'h3000, 1'b1);
    redirect(32'h2000, "R10");
    pop_expect(32'h2000, 1'b1, 32'h3000, "R4");
    pop_expect(32'h3000, 1'b0, 32'h3020, "R4");
  endtask

  task automatic t_not_taken();
    update(32'h3800, 32'h4800, 1'b0);
    redirect(32'h3800, "R10");
    pop_expect(32'h3800, 1'b0, 32'h3820, "R5");
    pop_expect(32'h3820, 1'b0, 32'h3840, "R5");
  endtask

  task automatic t_unaligned();
    redirect(32'h4011, "R10");
    pop_expect(32'h4000, 1'b0, 32'h4020, "R3");
  endtask

  task automatic t_alias();
    // same index [12:5], different tag: larger table keeps only the later one
    update(32'h5000, 32'h6400, 1'b1);
    update(32'h7000, 32'h8800, 1'b1);
    redirect(32'h5000, "R10");
    pop_expect(32'h5000, 1'b0, 32'h5020, "R6");
    pop_expect(32'h5020, 1'b0, 32'h5040, "R6");
  endtask

  task automatic t_round_robin();
    int gap;
    update(32'h0000_A000, 32'h0000_B000, 1'b1);
    for (int i = 1; i <= 63; i++) update(32'h0010_0000 + i * 32, 32'h0020_0000, 1'b1);
    gap_after(32'h0000_A000, 32'h0000_B000, "R8", gap);
    check(gap == 0, "R7", "gap with fast hit", gap, 0);
    update(32'h0010_0000 + 64 * 32, 32'h0020_0000, 1'b1);
    gap_after(32'h0000_A000, 32'h0000_B000, "R8", gap);
    check(gap != 0, "R8", "gap after eviction", gap, 2);
  endtask

  task automatic t_stall_flush();
    redirect(32'h0000_C000, "R10");
    repeat (40) @(negedge clk);
    for (int k = 0; k < 12; k++)
      pop_expect(32'h0000_C000 + k * 32, 1'b0, 32'h0000_C020 + k * 32, "R9");
    repeat (30) @(negedge clk);
    redirect(32'h0000_D000, "R10");
    pop_expect(32'h0000_D000, 1'b0, 32'h0000_D020, "R10");
  endtask

  initial begin
    t_reset();
    t_taken();
    t_not_taken();
    t_unaligned();
    t_alias();
    t_round_robin();
    t_stall_flush();
    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule